// File: doc/BRIEF.md
# Double-Ended Hardware Ring Queue

A single ring queue whose storage, head index and tail index live entirely in hardware. Elements can enter or leave at either end. Each end operation moves one whole element, and at most one operation is accepted per cycle. Every operation returns exactly one response: a pop returns the removed element, and an illegal or impossible operation returns an error flag and leaves the queue untouched.

A configuration port sets three things:
- the ring size in storage slots;
- an element-size code;
- an operating mode.

Two of the modes store a credential word beside every element, so each element occupies two slots. The queue-manager mode also stores a packet length per element and keeps a running sum of the queued lengths. A clear command empties the queue without touching the configuration. Status outputs report the configured size, the occupancy, the free count and a full flag.

Top module: `ring_deque`

## Requirements
- R1: After reset the queue is empty: `st_occ`=0, `st_size`=DEPTH, `st_free`=DEPTH, `st_full`=0, `st_mode`=0, `st_qlen`=0, and no response is pending.
- R2: A configuration is rejected with `cfg_err`=1, and the previous configuration is kept, in each of these cases: the mode is 4 or above; the size code is 7; the mode is 3 with a size code other than 1; the size is 0 or above DEPTH; the mode is 2 or 3 with an odd size. Mode codes: 0 plain ring, 1 message, 2 credential, 3 queue manager. Size codes 0..6 stand for 4, 8, 16, 32, 64, 128 and 256 bytes.
- R3: A configuration presented while `st_occ` is nonzero is rejected with `cfg_err`=1 and changes nothing.
- R4: Operation codes are 0 push at the tail, 1 pop from the head, 2 push at the head, 3 pop from the tail. Together they give deque order, and the indices wrap modulo the element capacity.
- R5: In mode 0, codes 2 and 3 return an error and change no state.
- R6: A push when full, or a pop when empty, returns an error and changes no state.
- R7: In modes 2 and 3 the element capacity is half the configured size, and the credential word pushed with an element is returned when it is popped. In modes 0 and 1, `rsp_cred` is 0.
- R8: In mode 3, `st_qlen` is the sum of the lengths of the queued elements, and a pop returns the element's length on `rsp_len`.
- R9: `st_occ` counts the elements held. `st_free` is the capacity minus `st_occ`. `st_full` is 1 exactly when `st_free` is 0.
- R10: `clr` empties the queue and zeroes `st_qlen` at the next edge while keeping the configuration. `req_ready` is low while `clr` or `cfg_valid` is high.
- R11: Each accepted request produces one `rsp_valid` pulse at the next clock edge, and each configuration produces one `cfg_ack` pulse at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Empties the queue |
| cfg_valid | input | 1 | Configuration request |
| cfg_size | input | SW | Ring size in slots |
| cfg_esz | input | 3 | Element size code |
| cfg_mode | input | 3 | Operating mode |
| cfg_ack | output | 1 | Configuration handled |
| cfg_err | output | 1 | Configuration rejected |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Operation can be accepted |
| req_op | input | 2 | Operation code |
| req_data | input | DW | Element data to push |
| req_cred | input | DW | Credential word to push |
| req_len | input | LW | Packet length to push |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Operation failed |
| rsp_data | output | DW | Popped data |
| rsp_cred | output | DW | Popped credential word |
| rsp_len | output | LW | Popped length |
| st_size | output | SW | Configured size in slots |
| st_mode | output | 2 | Active mode |
| st_occ | output | SW | Elements held |
| st_free | output | SW | Free element count |
| st_full | output | 1 | Queue full |
| st_qlen | output | QW | Sum of queued lengths |

## Verification
An operation accepted at one rising edge has its response, the new occupancy, the new free count and the new length sum all visible after that same edge. A configuration or clear likewise takes effect at the edge that samples it, and its acknowledgement appears after that edge. The bench therefore drives each input at a falling edge and reads every result at the following falling edge, half a cycle after the edge that produced it. For the timing check it also looks one further falling edge on, to confirm that the response strobe has dropped.

// File: rtl/ring_deque.sv
module ring_deque #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int QW    = 24,
  localparam int IW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cfg_valid,
  input  logic [SW-1:0] cfg_size,
  input  logic [2:0]    cfg_esz,
  input  logic [2:0]    cfg_mode,
  output logic          cfg_ack,
  output logic          cfg_err,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_cred,
  input  logic [LW-1:0] req_len,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] rsp_cred,
  output logic [LW-1:0] rsp_len,
  output logic [SW-1:0] st_size,
  output logic [1:0]    st_mode,
  output logic [SW-1:0] st_occ,
  output logic [SW-1:0] st_free,
  output logic          st_full,
  output logic [QW-1:0] st_qlen
);

  logic [DW-1:0] dmem [DEPTH];
  logic [DW-1:0] cmem [DEPTH];
  logic [LW-1:0] lmem [DEPTH];

  logic [SW-1:0] size_q, occ_q;
  logic [1:0]    mode_q;
  logic [2:0]    esz_q;
  logic [IW-1:0] head_q, tail_q;
  logic [QW-1:0] qlen_q;

  function automatic logic [IW-1:0] step_up(input logic [IW-1:0] i, input logic [SW-1:0] c);
    return (SW'(i) + SW'(1) == c) ? '0 : i + IW'(1);
  endfunction

  function automatic logic [IW-1:0] step_dn(input logic [IW-1:0] i, input logic [SW-1:0] c);
    return (i == '0) ? IW'(c - SW'(1)) : i - IW'(1);
  endfunction

  wire           two_slot = mode_q[1];
  wire           qm_mode  = (mode_q == 2'd3);
  wire [SW-1:0]  cap      = two_slot ? (size_q >> 1) : size_q;
  wire           q_full   = (occ_q == cap);
  wire           q_empty  = (occ_q == '0);
  wire           is_pop   = req_op[0];

  assign req_ready = !clr && !cfg_valid;
  wire acc      = req_valid && req_ready;
  wire bad_end  = (mode_q == 2'd0) && req_op[1];
  wire op_err   = bad_end || (!is_pop && q_full) || (is_pop && q_empty);
  wire op_ok    = acc && !op_err;

  wire [IW-1:0] head_dn = step_dn(head_q, cap);
  wire [IW-1:0] tail_dn = step_dn(tail_q, cap);
  wire [IW-1:0] head_up = step_up(head_q, cap);
  wire [IW-1:0] tail_up = step_up(tail_q, cap);

  logic [IW-1:0] idx;
  always_comb begin
    case (req_op)
      2'd0:    idx = tail_q;
      2'd1:    idx = head_q;
      2'd2:    idx = head_dn;
      default: idx = tail_dn;
    endcase
  end

  wire mode_bad = cfg_mode[2];
  wire esz_bad  = (cfg_esz == 3'd7) || (cfg_mode == 3'd3 && cfg_esz != 3'd1);
  wire size_bad = (cfg_size == '0) || (cfg_size > SW'(DEPTH)) ||
                  (cfg_mode[1] && cfg_size[0]);
  wire cfg_bad  = mode_bad || esz_bad || size_bad || !q_empty;
  wire cfg_take = cfg_valid && !clr && !cfg_bad;

  always_ff @(posedge clk) begin
    if (op_ok && !is_pop) begin
      dmem[idx] <= req_data;
      cmem[idx] <= req_cred;
      lmem[idx] <= req_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= SW'(DEPTH);
      mode_q    <= 2'd0;
      esz_q     <= 3'd0;
      occ_q     <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      qlen_q    <= '0;
      cfg_ack   <= 1'b0;
      cfg_err   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      rsp_cred  <= '0;
      rsp_len   <= '0;
    end else begin
      cfg_ack   <= cfg_valid && !clr;
      cfg_err   <= cfg_valid && !clr && cfg_bad;
      rsp_valid <= acc;
      rsp_err   <= acc && op_err;
      rsp_data  <= (op_ok && is_pop) ? dmem[idx] : '0;
      rsp_cred  <= (op_ok && is_pop && two_slot) ? cmem[idx] : '0;
      rsp_len   <= (op_ok && is_pop && qm_mode) ? lmem[idx] : '0;
      if (clr) begin
        occ_q  <= '0;
        head_q <= '0;
        tail_q <= '0;
        qlen_q <= '0;
      end else if (cfg_take) begin
        size_q <= cfg_size;
        mode_q <= cfg_mode[1:0];
        esz_q  <= cfg_esz;
        head_q <= '0;
        tail_q <= '0;
        qlen_q <= '0;
      end else if (op_ok) begin
        case (req_op)
          2'd0: tail_q <= tail_up;
          2'd1: head_q <= head_up;
          2'd2: head_q <= head_dn;
          default: tail_q <= tail_dn;
        endcase
        occ_q <= is_pop ? occ_q - SW'(1) : occ_q + SW'(1);
        if (qm_mode)
          qlen_q <= is_pop ? qlen_q - QW'(lmem[idx]) : qlen_q + QW'(req_len);
      end
    end
  end

  assign st_size = size_q;
  assign st_mode = mode_q;
  assign st_occ  = occ_q;
  assign st_free = cap - occ_q;
  assign st_full = q_full;
  assign st_qlen = qlen_q;

endmodule

// File: rtl/ring_deque_chk.sv
module ring_deque_chk #(
  parameter int DEPTH = 16,
  parameter int QW    = 24,
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic          cfg_ack,
  input logic          cfg_err,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [SW-1:0] st_size,
  input logic [1:0]    st_mode,
  input logic [SW-1:0] st_occ,
  input logic [QW-1:0] st_qlen
);

  a_r6_err_keeps_occ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> st_occ == $past(st_occ));

  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && !$past(req_op[0]) |-> st_occ == $past(st_occ) + SW'(1));

  a_r5_ring_mode_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_op[1]) && $past(st_mode) == 2'd0 |-> rsp_err);

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st_occ <= st_size);

  a_r2_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack && cfg_err |-> st_size == $past(st_size) && st_mode == $past(st_mode));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> st_occ == '0 && st_qlen == '0);

  a_r11_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

endmodule

bind ring_deque ring_deque_chk #(.DEPTH(DEPTH), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .cfg_ack(cfg_ack),
  .cfg_err(cfg_err), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .st_size(st_size), .st_mode(st_mode), .st_occ(st_occ), .st_qlen(st_qlen)
);

// File: tb/ring_deque_tb.sv
`timescale 1ns/1ps
module ring_deque_tb;
  localparam int DEPTH = 16, DW = 32, LW = 16, QW = 24;
  localparam int SW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic cfg_valid = 1'b0;
  logic [SW-1:0] cfg_size = '0;
  logic [2:0] cfg_esz = '0, cfg_mode = '0;
  logic cfg_ack, cfg_err, req_ready, rsp_valid, rsp_err, st_full;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [DW-1:0] req_data = '0, req_cred = '0, rsp_data, rsp_cred;
  logic [LW-1:0] req_len = '0, rsp_len;
  logic [SW-1:0] st_size, st_occ, st_free;
  logic [1:0] st_mode;
  logic [QW-1:0] st_qlen;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_deque #(.DEPTH(DEPTH), .DW(DW), .LW(LW), .QW(QW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_valid(cfg_valid),
    .cfg_size(cfg_size), .cfg_esz(cfg_esz), .cfg_mode(cfg_mode),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .req_cred(req_cred), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .rsp_cred(rsp_cred),
    .rsp_len(rsp_len), .st_size(st_size), .st_mode(st_mode),
    .st_occ(st_occ), .st_free(st_free), .st_full(st_full), .st_qlen(st_qlen)
  );

  // {op[1:0], data[7:0], err, edata[7:0], eocc[4:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 8'h11, 1'b0, 8'h00, 5'd1},
    {2'd0, 8'h22, 1'b0, 8'h00, 5'd2},
    {2'd2, 8'h33, 1'b0, 8'h00, 5'd3},
    {2'd3, 8'h00, 1'b0, 8'h22, 5'd2},
    {2'd1, 8'h00, 1'b0, 8'h33, 5'd1},
    {2'd0, 8'h44, 1'b0, 8'h00, 5'd2},
    {2'd0, 8'h55, 1'b0, 8'h00, 5'd3},
    {2'd2, 8'h66, 1'b0, 8'h00, 5'd4},
    {2'd0, 8'h77, 1'b1, 8'h00, 5'd4},
    {2'd1, 8'h00, 1'b0, 8'h66, 5'd3},
    {2'd1, 8'h00, 1'b0, 8'h11, 5'd2},
    {2'd1, 8'h00, 1'b0, 8'h44, 5'd1},
    {2'd3, 8'h00, 1'b0, 8'h55, 5'd0},
    {2'd1, 8'h00, 1'b1, 8'h00, 5'd0},
    {2'd3, 8'h00, 1'b1, 8'h00, 5'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [DW-1:0] d,
                    input logic [DW-1:0] c, input logic [LW-1:0] l);
    req_op = o; req_data = d; req_cred = c; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] m, input logic [2:0] e, input logic [SW-1:0] s);
    cfg_mode = m; cfg_esz = e; cfg_size = s; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 occ", st_occ, 0);
    chk("R1 size", st_size, DEPTH);
    chk("R1 free", st_free, DEPTH);
    chk("R1 full", st_full, 0);
    chk("R1 mode", st_mode, 0);
    chk("R1 rsp", rsp_valid, 0);

    cfg(3'd1, 3'd2, SW'(4));
    chk("R11 cfg_ack", cfg_ack, 1);
    chk("R2 good cfg", cfg_err, 0);
    chk("R2 size", st_size, 4);
    chk("R9 free", st_free, 4);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][23:22], DW'(VEC[i][21:14]), 32'h55, '0);
      chk("R11 rsp_valid", rsp_valid, 1);
      chk("R4/R6 err", rsp_err, VEC[i][13]);
      chk("R4 data", rsp_data, VEC[i][12:5]);
      chk("R9 occ", st_occ, VEC[i][4:0]);
      chk("R7 cred zero", rsp_cred, 0);
    end
    @(negedge clk);
    chk("R11 strobe drops", rsp_valid, 0);

    for (int i = 1; i <= 4; i++) op(2'd0, DW'(i), '0, '0);
    chk("R9 full", st_full, 1);
    chk("R9 free zero", st_free, 0);
    op(2'd0, 32'h9, '0, '0);
    chk("R6 push full err", rsp_err, 1);
    chk("R6 occ kept", st_occ, 4);

    cfg(3'd0, 3'd0, SW'(8));
    chk("R3 busy cfg err", cfg_err, 1);
    chk("R3 size kept", st_size, 4);
    chk("R3 mode kept", st_mode, 1);

    clr = 1'b1;
    #1 chk("R10 ready low", req_ready, 0);
    @(negedge clk);
    clr = 1'b0;
    chk("R10 occ clear", st_occ, 0);
    chk("R10 cfg kept", st_size, 4);
    op(2'd0, 32'hAB, '0, '0);
    op(2'd1, '0, '0, '0);
    chk("R10 reuse", rsp_data, 32'hAB);

    cfg(3'd4, 3'd0, SW'(4));  chk("R2 mode 4", cfg_err, 1);
    cfg(3'd1, 3'd7, SW'(4));  chk("R2 esz 7", cfg_err, 1);
    cfg(3'd3, 3'd2, SW'(8));  chk("R2 qm esz", cfg_err, 1);
    cfg(3'd2, 3'd0, SW'(3));  chk("R2 odd size", cfg_err, 1);
    cfg(3'd0, 3'd0, SW'(0));  chk("R2 zero size", cfg_err, 1);
    cfg(3'd0, 3'd0, SW'(17)); chk("R2 big size", cfg_err, 1);
    chk("R2 size kept", st_size, 4);

    cfg(3'd0, 3'd0, SW'(8));
    chk("R5 cfg ok", cfg_err, 0);
    op(2'd0, 32'h10, '0, '0);
    op(2'd2, 32'h20, '0, '0);
    chk("R5 push head err", rsp_err, 1);
    chk("R5 occ kept", st_occ, 1);
    op(2'd3, '0, '0, '0);
    chk("R5 pop tail err", rsp_err, 1);
    op(2'd1, '0, '0, '0);
    chk("R5 content kept", rsp_data, 32'h10);

    cfg(3'd2, 3'd3, SW'(4));
    chk("R7 cfg ok", cfg_err, 0);
    chk("R7 half cap", st_free, 2);
    op(2'd0, 32'h1, 32'hC1, '0);
    op(2'd2, 32'h2, 32'hC2, '0);
    chk("R7 full at 2", st_full, 1);
    op(2'd0, 32'h3, 32'hC3, '0);
    chk("R7 third push err", rsp_err, 1);
    op(2'd3, '0, '0, '0);
    chk("R7 tail data", rsp_data, 32'h1);
    chk("R7 tail cred", rsp_cred, 32'hC1);
    op(2'd1, '0, '0, '0);
    chk("R7 head cred", rsp_cred, 32'hC2);

    cfg(3'd3, 3'd1, SW'(8));
    chk("R8 cfg ok", cfg_err, 0);
    op(2'd0, 32'hA, '0, 16'd100);
    op(2'd2, 32'hB, '0, 16'd50);
    chk("R8 qlen sum", st_qlen, 150);
    op(2'd1, '0, '0, '0);
    chk("R8 head len", rsp_len, 50);
    chk("R8 qlen after pop", st_qlen, 100);
    op(2'd3, '0, '0, '0);
    chk("R8 tail len", rsp_len, 100);
    chk("R8 qlen zero", st_qlen, 0);

    finish_run();
  end
endmodule